// File: doc/BRIEF.md
# Serial-Bus Octal DAC Register Front End

This block is the digital side of an eight-channel, 8-bit digital-to-analog converter that is programmed over a two-wire serial bus. The bus clock and data lines arrive asynchronously. Each line passes through a two-stage synchroniser clocked by the system clock. Start, stop and clock edges are then found on the synchronised samples. The block acknowledges only write transfers whose device byte carries its fixed prefix and matches the two address straps.

After the device byte, a transfer carries pairs of bytes: a command byte, then a data byte. A command byte chooses a channel. It can also request that all staged channel values be cleared, and it can arm or disarm low-power mode. A data byte lands in the staging register of the chosen channel. Staged values, a pending clear and the low-power request all reach the outputs together, at the stop condition. This allows several channels to change in the same cycle.

The acknowledge is driven as an open-drain enable. It is high only while the block pulls the data line low during the ninth clock of a byte it accepts.

Top module: `i2cDacFront`

## Requirements
- R1: While reset is held and just after it is released, every channel code is zero, `pwrDown` is 0 and `sdaOe` is 0.
- R2: A start is data falling while the clock is high, and a stop is data rising while the clock is high. Data changes while the clock is low are never taken as start or stop. Bits are sampled on the rising clock, most significant bit first.
- R3: A device byte equal to {5'b01010, addrStrap[1], addrStrap[0], 1'b0}, where bit 0 being 0 means write, is acknowledged by `sdaOe` high during its ninth clock.
- R4: A device byte with a different prefix, different strap bits or bit 0 = 1 is not acknowledged. No later byte is acknowledged or has any effect on the outputs until the next start.
- R5: A command byte uses bit 4 = clear-all, bit 3 = low-power request and bits 2..0 = channel. Bits 7..5 are ignored. Every command byte is acknowledged.
- R6: The byte after a command is a data byte, and it is written to the staging register of the selected channel. It is acknowledged. The next byte is again a command.
- R7: Channel codes change only when a stop is detected. At that point every channel takes its staged value, so all channels written in one transfer change together.
- R8: A command with clear-all set zeroes every staging register at once. The outputs keep their old values until the stop.
- R9: `pwrDown` takes the low-power request of the most recent command, and only when a stop is detected. A later command with the request clear returns it to 0 at the next stop.
- R10: A start that arrives in the middle of a transfer drops any partly received byte and begins device-byte matching again. Data bytes already accepted stay staged.
- R11: `sdaOe` is released at the falling clock that ends the acknowledge clock. It is never high while data bits are being received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line (asynchronous) |
| sdaIn | input | 1 | Bus data line (asynchronous) |
| addrStrap | input | 2 | Device address straps; bit 1 is compared to device-byte bit 2, bit 0 to bit 1 |
| sdaOe | output | 1 | Open-drain enable: 1 pulls the data line low for the acknowledge |
| dacCodes | output | 64 | Channel codes; channel n occupies bits n*8+7 down to n*8 |
| pwrDown | output | 1 | Low-power mode flag |

## Verification
Each line reaches the control logic about three system clocks after it changes: two synchroniser stages plus the previous-sample register used for edge detection. The acknowledge enable rises one clock after the falling bus clock that ends the eighth bit. The outputs change one clock after the stop is seen. The bench drives the bus with a quarter period of eight system clocks and reads the acknowledge in the middle of the ninth high phase. It checks release eight clocks after the following falling edge and reads the outputs sixteen clocks after the stop edge, so every result is already settled when it is sampled. Outputs are also compared after each command and data byte, before the stop, to show that nothing changes early.

// File: rtl/i2cDacPkg.sv
package i2cDacPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_SKIP
  } busState_t;

  // Strobes from the bus control to the register datapath
  typedef struct packed {
    logic       cmdLoad;
    logic       dataLoad;
    logic       commit;
    logic [7:0] byteVal;
  } dacStrobe_t;
endpackage

// File: rtl/i2cDacCtrl.sv
module i2cDacCtrl
  import i2cDacPkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b01010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] addrStrap,
  output logic       sdaOe,
  output dacStrobe_t strb
);
  localparam int SYNC_STAGES = 2;
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclP, sdaP, sclS, sdaS;
  logic startSeen, stopSeen, sclRise, sclFall, byteDone, addrOk, ackNow;
  logic [7:0] shReg;
  logic [3:0] bitCnt;
  logic ackPhase;
  busState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSh <= '1;
      sdaSh <= '1;
      sclP  <= 1'b1;
      sdaP  <= 1'b1;
    end else begin
      sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclP  <= sclS;
      sdaP  <= sdaS;
    end
  end

  assign sclS      = sclSh[SYNC_STAGES-1];
  assign sdaS      = sdaSh[SYNC_STAGES-1];
  assign startSeen = sclS & sclP & sdaP & ~sdaS;
  assign stopSeen  = sclS & sclP & ~sdaP & sdaS;
  assign sclRise   = sclS & ~sclP;
  assign sclFall   = ~sclS & sclP;
  assign byteDone  = sclFall & ~ackPhase & (bitCnt == BITS_PER_BYTE)
                   & (state != ST_IDLE) & (state != ST_SKIP);
  assign addrOk    = (shReg[7:3] == ADDR_PREFIX) && (shReg[2:1] == addrStrap)
                   && !shReg[0];

  always_comb begin
    ackNow    = 1'b0;
    nextState = state;
    case (state)
      ST_ADDR: begin ackNow = addrOk; nextState = addrOk ? ST_CMD : ST_SKIP; end
      ST_CMD:  begin ackNow = 1'b1;   nextState = ST_DATA; end
      ST_DATA: begin ackNow = 1'b1;   nextState = ST_CMD;  end
      default: begin ackNow = 1'b0;   nextState = state;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      shReg    <= '0;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      sdaOe    <= 1'b0;
    end else if (startSeen) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      sdaOe    <= 1'b0;
    end else if (stopSeen) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      sdaOe    <= 1'b0;
    end else if (state != ST_IDLE && state != ST_SKIP) begin
      if (sclRise && !ackPhase && bitCnt != BITS_PER_BYTE) begin
        shReg  <= {shReg[6:0], sdaS};
        bitCnt <= bitCnt + 4'd1;
      end
      if (byteDone) begin
        bitCnt   <= '0;
        ackPhase <= 1'b1;
        sdaOe    <= ackNow;
        state    <= nextState;
      end else if (sclFall && ackPhase) begin
        ackPhase <= 1'b0;
        sdaOe    <= 1'b0;
      end
    end
  end

  assign strb.cmdLoad  = byteDone && (state == ST_CMD);
  assign strb.dataLoad = byteDone && (state == ST_DATA);
  assign strb.commit   = stopSeen;
  assign strb.byteVal  = shReg;
endmodule

// File: rtl/i2cDacRegs.sv
module i2cDacRegs
  import i2cDacPkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dacStrobe_t        strb,
  output logic [NCH*DW-1:0] dacCodes,
  output logic              pwrDown
);
  localparam int SELW    = $clog2(NCH);
  localparam int CLR_BIT = 4;
  localparam int PD_BIT  = 3;

  logic [SELW-1:0] chanSel;
  logic pdPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanSel <= '0;
      pdPend  <= 1'b0;
      pwrDown <= 1'b0;
    end else begin
      if (strb.cmdLoad) begin
        chanSel <= strb.byteVal[SELW-1:0];
        pdPend  <= strb.byteVal[PD_BIT];
      end
      if (strb.commit) pwrDown <= pdPend;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [DW-1:0] stageReg, liveReg;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageReg <= '0;
        liveReg  <= '0;
      end else begin
        if (strb.cmdLoad && strb.byteVal[CLR_BIT])
          stageReg <= '0;
        else if (strb.dataLoad && chanSel == SELW'(ch))
          stageReg <= strb.byteVal[DW-1:0];
        if (strb.commit) liveReg <= stageReg;
      end
    end
    assign dacCodes[ch*DW +: DW] = liveReg;
  end
endmodule

// File: rtl/i2cDacFront.sv
module i2cDacFront
  import i2cDacPkg::*;
#(
  parameter int         NCH         = 8,
  parameter int         DW          = 8,
  parameter logic [4:0] ADDR_PREFIX = 5'b01010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        addrStrap,
  output logic              sdaOe,
  output logic [NCH*DW-1:0] dacCodes,
  output logic              pwrDown
);
  dacStrobe_t strb;

  i2cDacCtrl #(.ADDR_PREFIX(ADDR_PREFIX)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrStrap(addrStrap), .sdaOe(sdaOe), .strb(strb)
  );

  i2cDacRegs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dacCodes(dacCodes), .pwrDown(pwrDown)
  );
endmodule

// File: rtl/i2cDacFront_chk.sv
module i2cDacFront_chk
  import i2cDacPkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic [NCH*DW-1:0] dacCodes,
  input logic              pwrDown,
  input dacStrobe_t        strb
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dacCodes == '0) && !pwrDown && !sdaOe);

  // R7
  codes_at_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dacCodes != $past(dacCodes)) |-> $past(strb.commit));

  // R9
  pd_at_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrDown != $past(pwrDown)) |-> $past(strb.commit));

  // R8
  cmd_defers_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdLoad |=> $stable(dacCodes) && $stable(pwrDown));

  // R6
  one_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.cmdLoad, strb.dataLoad, strb.commit}));

  // R11
  ack_not_at_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !sdaOe);
endmodule

bind i2cDacFront i2cDacFront_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .dacCodes(dacCodes),
  .pwrDown(pwrDown), .strb(strb)
);

// File: tb/i2cDacFront_bench.sv
`timescale 1ns/1ps
module i2cDacFront_bench;
  localparam int NCH = 8;
  localparam int DW  = 8;
  localparam int Q   = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, sclDrv = 1'b1, sdaDrv = 1'b1;
  logic [1:0] strap = 2'b01;
  logic sdaOe, pwrDown;
  logic [NCH*DW-1:0] dacCodes;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] mIn [NCH];
  logic [7:0] mOut[NCH];
  int mSel = 0;
  bit mPdPend = 1'b0, mPd = 1'b0;

  i2cDacFront u_i2cDacFront (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaDrv),
    .addrStrap(strap), .sdaOe(sdaOe), .dacCodes(dacCodes), .pwrDown(pwrDown)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] codeOf(int ch);
    return dacCodes[ch*DW +: DW];
  endfunction

  task automatic checkOutputs(string req);
    for (int ch = 0; ch < NCH; ch++)
      check(codeOf(ch) == mOut[ch], req, $sformatf("code ch%0d", ch), codeOf(ch), mOut[ch]);
    check(pwrDown == mPd, req, "pwrDown", pwrDown, mPd);
  endtask

  function automatic logic [7:0] devByte(logic [1:0] s);
    return {5'b01010, s, 1'b0};
  endfunction

  task automatic busStart();
    if (!sclDrv) begin
      sdaDrv = 1'b1; tick(Q);
      sclDrv = 1'b1; tick(Q);
    end
    sdaDrv = 1'b0; tick(2*Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; tick(Q);
    sclDrv = 1'b1; tick(Q);
    sdaDrv = 1'b1; tick(2*Q);
    for (int ch = 0; ch < NCH; ch++) mOut[ch] = mIn[ch];
    mPd = mPdPend;
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaDrv = b[i]; tick(Q);
      sclDrv = 1'b1; tick(Q);
      if (i == 7) check(sdaOe == 1'b0, "R11", "oe during data", sdaOe, 0);
      tick(Q);
      sclDrv = 1'b0; tick(Q);
    end
  endtask

  task automatic sendByte(logic [7:0] b, bit expAck, string req);
    sendBits(b, 8);
    sdaDrv = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(Q);
    check(sdaOe == expAck, req, "ack", sdaOe, expAck);
    tick(Q);
    sclDrv = 1'b0; tick(Q);
    check(sdaOe == 1'b0, "R11", "oe release", sdaOe, 0);
  endtask

  task automatic sendCmd(logic [7:0] c);
    sendByte(c, 1'b1, "R5");
    if (c[4]) for (int ch = 0; ch < NCH; ch++) mIn[ch] = 8'h00;
    mSel = int'(c[2:0]);
    mPdPend = c[3];
    checkOutputs("R8");
  endtask

  task automatic sendData(logic [7:0] d);
    sendByte(d, 1'b1, "R6");
    mIn[mSel] = d;
    checkOutputs("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_2468));
    for (int ch = 0; ch < NCH; ch++) begin mIn[ch] = 8'h00; mOut[ch] = 8'h00; end
    tick(10);
    checkOutputs("R1");
    check(sdaOe == 1'b0, "R1", "oe in reset", sdaOe, 0);
    rstN = 1'b1; tick(6);
    checkOutputs("R1");

    // R3 R6 R7 R2: two channels, MSB-first values, update together
    busStart();
    sendByte(devByte(strap), 1'b1, "R3");
    sendCmd(8'h02); sendData(8'h5A);
    sendCmd(8'h07); sendData(8'hC3);
    busStop(); checkOutputs("R7");
    check(codeOf(2) == 8'h5A, "R2", "msb first", codeOf(2), 8'h5A);

    // R5 reserved bits ignored
    busStart();
    sendByte(devByte(strap), 1'b1, "R3");
    sendCmd(8'hE1); sendData(8'h11);
    busStop(); checkOutputs("R5");

    // R8 clear-all deferred to stop
    busStart();
    sendByte(devByte(strap), 1'b1, "R3");
    sendCmd(8'h13); sendData(8'h77);
    busStop(); checkOutputs("R8");

    // R9 low-power on and off at stop
    busStart();
    sendByte(devByte(strap), 1'b1, "R3");
    sendCmd(8'h08); sendData(8'h01);
    check(pwrDown == 1'b0, "R9", "pd before stop", pwrDown, 0);
    busStop(); checkOutputs("R9");
    busStart();
    sendByte(devByte(strap), 1'b1, "R3");
    sendCmd(8'h04); sendData(8'h44);
    busStop(); checkOutputs("R9");

    // R4 mismatches: straps, prefix, read bit
    busStart();
    sendByte(devByte(~strap), 1'b0, "R4");
    sendByte(8'h01, 1'b0, "R4"); sendByte(8'hFF, 1'b0, "R4");
    busStop(); checkOutputs("R4");
    busStart();
    sendByte(8'h92, 1'b0, "R4");
    sendByte(8'h00, 1'b0, "R4");
    busStop(); checkOutputs("R4");
    busStart();
    sendByte(devByte(strap) | 8'h01, 1'b0, "R4");
    busStop(); checkOutputs("R4");

    // R10 repeated start mid-byte
    busStart();
    sendByte(devByte(strap), 1'b1, "R3");
    sendCmd(8'h02); sendData(8'h55);
    sendBits(8'hFF, 3);
    busStart();
    sendByte(devByte(strap), 1'b1, "R10");
    sendCmd(8'h05); sendData(8'hAA);
    busStop(); checkOutputs("R10");

    // R3 other strap value
    strap = 2'b10; tick(4);
    busStart();
    sendByte(devByte(strap), 1'b1, "R3");
    sendCmd(8'h06); sendData(8'h3C);
    busStop(); checkOutputs("R3");

    // random transfers
    for (int t = 0; t < 25; t++) begin
      int pairs;
      busStart();
      if ($urandom_range(0, 99) < 15) begin
        sendByte(devByte(~strap), 1'b0, "R4");
        sendByte(8'($urandom), 1'b0, "R4");
      end else begin
        sendByte(devByte(strap), 1'b1, "R3");
        pairs = $urandom_range(1, 3);
        for (int p = 0; p < pairs; p++) begin
          logic [7:0] c;
          c = 8'($urandom);
          c[4] = ($urandom_range(0, 5) == 0);
          sendCmd(c);
          sendData(8'($urandom));
        end
      end
      busStop(); checkOutputs("R7");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule